// File: doc/BRIEF.md
# Two-Sided Mailbox Register Bank

This block is a small byte-wide register bank placed between a host processor and a management controller. Each agent has its own register port with address, write enable, write data and combinational read data. Both ports see one 32-byte address map. It contains a 16-byte shared message area, two status bytes, one control byte per side and two interrupt-enable bytes per side. The block drives one interrupt line toward each agent.

A side rings the other with a send bit in its own control byte. The ring sets a pending bit in the peer's control byte. Pending bits and status bits are cleared by writing one to them. Each interrupt line combines the side's unmasked pending bit with the status bits that side has enabled. The block gives no meaning to the contents of the message area.

Top module: `mbox_regs`

## Requirements
- R1: After the asynchronous reset, every register reads 0x00 from both ports and both interrupt outputs are low.
- R2: Addresses 0x00 to 0x0F form a shared message area. Either side may write any byte there, and both read ports return the stored value from the cycle after the write.
- R3: When both sides write the same message address in the same cycle, the management side's data is stored. Writes to two different addresses in one cycle both take effect.
- R4: The host control byte is at 0x13 and the management control byte is at 0x12. A side that writes its own control byte with bit 0 set raises bit 7 (pending) of the other side's control byte. Bit 0 always reads back as 0.
- R5: A side clears bit 7 of its own control byte by writing 1 to it. Writing 0 to bit 7 leaves it unchanged. Bit 1 (mask) is stored as written, and bits 6..2 read as 0.
- R6: If a ring toward a side and that side's own clear of its pending bit land in the same cycle, the pending bit stays set.
- R7: Status bytes are at 0x10 and 0x11. A management-side write sets the bits written as 1. A host-side write clears the bits written as 1. When a set and a clear hit the same bit in the same cycle, the set wins.
- R8: The management enable bytes are at 0x14 and 0x15, and the host enable bytes are at 0x16 and 0x17. Only the owning side can write them. Writes to the other side's enable bytes or control byte are ignored, and so is a send bit written there.
- R9: A side's interrupt output is high when its pending bit is set and its mask bit is clear, or when any status bit is set in a byte whose matching enable byte of that side has that bit set. Enable byte 0 pairs with status 0x10 and enable byte 1 with status 0x11.
- R10: Addresses 0x18 to 0x1F read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_we_i | input | 1 | Host write enable |
| h_addr_i | input | 5 | Host byte address |
| h_wdata_i | input | 8 | Host write data |
| h_rdata_o | output | 8 | Host read data, combinational from h_addr_i |
| m_we_i | input | 1 | Management write enable |
| m_addr_i | input | 5 | Management byte address |
| m_wdata_i | input | 8 | Management write data |
| m_rdata_o | output | 8 | Management read data, combinational from m_addr_i |
| h_irq_o | output | 1 | Interrupt toward the host |
| m_irq_o | output | 1 | Interrupt toward the management side |

## Verification
Three pairs of actions can land on the same cycle: both sides writing one message byte, a ring toward a side while that side clears its own pending bit, and a management set with a host clear on one status bit. The bench drives each pair from a single task, so both ports are active on the same clock edge. It then reads the result back from both ports. The stored value must be the management data, the pending bit must stay set, and the status bit must stay set while the bits that only the host cleared go to zero.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 5;
  localparam int unsigned MSG_N  = 16;
  localparam int unsigned STAT_N = 2;

  localparam logic [AW-1:0] STAT_BASE = 5'h10;
  localparam logic [AW-1:0] M_CTRL    = 5'h12;
  localparam logic [AW-1:0] H_CTRL    = 5'h13;
  localparam logic [AW-1:0] M_EN_BASE = 5'h14;
  localparam logic [AW-1:0] H_EN_BASE = 5'h16;

  localparam int unsigned SEND_B = 0;
  localparam int unsigned MASK_B = 1;
  localparam int unsigned PEND_B = 7;
endpackage

// File: rtl/mbox_msg_bank.sv
module mbox_msg_bank #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 8,
  parameter int unsigned N  = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 h_we_i,
  input  logic [AW-1:0]        h_addr_i,
  input  logic [DW-1:0]        h_wdata_i,
  input  logic                 m_we_i,
  input  logic [AW-1:0]        m_addr_i,
  input  logic [DW-1:0]        m_wdata_i,
  output logic [N-1:0][DW-1:0] bytes_o
);
  for (genvar i = 0; i < N; i++) begin : g_byte
    logic h_hit, m_hit;
    assign h_hit = h_we_i && (h_addr_i == AW'(i));
    assign m_hit = m_we_i && (m_addr_i == AW'(i));
    // management side wins a same-address collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    bytes_o[i] <= '0;
      else if (m_hit) bytes_o[i] <= m_wdata_i;
      else if (h_hit) bytes_o[i] <= h_wdata_i;
    end
  end
endmodule

// File: rtl/mbox_status_bank.sv
module mbox_status_bank #(
  parameter int unsigned   AW   = 5,
  parameter int unsigned   DW   = 8,
  parameter int unsigned   N    = 2,
  parameter logic [AW-1:0] BASE = 5'h10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 h_we_i,
  input  logic [AW-1:0]        h_addr_i,
  input  logic [DW-1:0]        h_wdata_i,
  input  logic                 m_we_i,
  input  logic [AW-1:0]        m_addr_i,
  input  logic [DW-1:0]        m_wdata_i,
  output logic [N-1:0][DW-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_stat
    logic [DW-1:0] set_v, clr_v;
    assign set_v = (m_we_i && m_addr_i == BASE + AW'(i)) ? m_wdata_i : '0;
    assign clr_v = (h_we_i && h_addr_i == BASE + AW'(i)) ? h_wdata_i : '0;
    // set applied after clear: a concurrent event is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_o[i] <= '0;
      else         stat_o[i] <= (stat_o[i] & ~clr_v) | set_v;
    end
  end
endmodule

// File: rtl/mbox_side.sv
module mbox_side
  import mbox_pkg::*;
#(
  parameter int unsigned   AW        = 5,
  parameter int unsigned   DW        = 8,
  parameter int unsigned   NS        = 2,
  parameter logic [AW-1:0] CTRL_ADDR = 5'h13,
  parameter logic [AW-1:0] EN_BASE   = 5'h16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  peer_ring_i,
  input  logic [NS-1:0][DW-1:0] stat_i,
  output logic                  ring_o,
  output logic [DW-1:0]         ctrl_o,
  output logic [NS-1:0][DW-1:0] en_o,
  output logic                  irq_o
);
  logic ctrl_wr, pend_q, mask_q;

  assign ctrl_wr = we_i && (addr_i == CTRL_ADDR);
  assign ring_o  = ctrl_wr && wdata_i[SEND_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      // peer ring overrides own clear in the same cycle
      pend_q <= (pend_q && !(ctrl_wr && wdata_i[PEND_B])) || peer_ring_i;
      if (ctrl_wr) mask_q <= wdata_i[MASK_B];
    end
  end

  always_comb begin
    ctrl_o         = '0;
    ctrl_o[PEND_B] = pend_q;
    ctrl_o[MASK_B] = mask_q;
  end

  for (genvar i = 0; i < NS; i++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                en_o[i] <= '0;
      else if (we_i && addr_i == EN_BASE + AW'(i)) en_o[i] <= wdata_i;
    end
  end

  logic stat_hit;
  always_comb begin
    stat_hit = 1'b0;
    for (int i = 0; i < NS; i++) stat_hit = stat_hit | (|(stat_i[i] & en_o[i]));
  end

  assign irq_o = (pend_q && !mask_q) || stat_hit;
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int unsigned AW     = mbox_pkg::AW,
  parameter int unsigned DW     = mbox_pkg::DW,
  parameter int unsigned MSG_N  = mbox_pkg::MSG_N,
  parameter int unsigned STAT_N = mbox_pkg::STAT_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_we_i,
  input  logic [AW-1:0] h_addr_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rdata_o,
  input  logic          m_we_i,
  input  logic [AW-1:0] m_addr_i,
  input  logic [DW-1:0] m_wdata_i,
  output logic [DW-1:0] m_rdata_o,
  output logic          h_irq_o,
  output logic          m_irq_o
);
  localparam int unsigned MW = $clog2(MSG_N);

  logic [MSG_N-1:0][DW-1:0]  msg;
  logic [STAT_N-1:0][DW-1:0] stat;
  logic [STAT_N-1:0][DW-1:0] h_en, m_en;
  logic [DW-1:0]             h_ctrl, m_ctrl;
  logic                      h_ring, m_ring;

  mbox_msg_bank #(.AW(AW), .DW(DW), .N(MSG_N)) i_msg (
    .clk_i, .rst_ni,
    .h_we_i, .h_addr_i, .h_wdata_i,
    .m_we_i, .m_addr_i, .m_wdata_i,
    .bytes_o(msg)
  );

  mbox_status_bank #(.AW(AW), .DW(DW), .N(STAT_N), .BASE(STAT_BASE)) i_stat (
    .clk_i, .rst_ni,
    .h_we_i, .h_addr_i, .h_wdata_i,
    .m_we_i, .m_addr_i, .m_wdata_i,
    .stat_o(stat)
  );

  mbox_side #(.AW(AW), .DW(DW), .NS(STAT_N), .CTRL_ADDR(H_CTRL), .EN_BASE(H_EN_BASE)) i_host (
    .clk_i, .rst_ni,
    .we_i(h_we_i), .addr_i(h_addr_i), .wdata_i(h_wdata_i),
    .peer_ring_i(m_ring), .stat_i(stat),
    .ring_o(h_ring), .ctrl_o(h_ctrl), .en_o(h_en), .irq_o(h_irq_o)
  );

  mbox_side #(.AW(AW), .DW(DW), .NS(STAT_N), .CTRL_ADDR(M_CTRL), .EN_BASE(M_EN_BASE)) i_mgmt (
    .clk_i, .rst_ni,
    .we_i(m_we_i), .addr_i(m_addr_i), .wdata_i(m_wdata_i),
    .peer_ring_i(h_ring), .stat_i(stat),
    .ring_o(m_ring), .ctrl_o(m_ctrl), .en_o(m_en), .irq_o(m_irq_o)
  );

  function automatic logic [DW-1:0] rd_sel(
    input logic [AW-1:0]             a,
    input logic [MSG_N-1:0][DW-1:0]  mb,
    input logic [STAT_N-1:0][DW-1:0] st,
    input logic [STAT_N-1:0][DW-1:0] he,
    input logic [STAT_N-1:0][DW-1:0] me,
    input logic [DW-1:0]             hc,
    input logic [DW-1:0]             mc
  );
    logic [DW-1:0] d;
    d = '0;
    if (a < AW'(MSG_N)) d = mb[a[MW-1:0]];
    for (int j = 0; j < STAT_N; j++) begin
      if (a == STAT_BASE + AW'(j)) d = st[j];
      if (a == H_EN_BASE + AW'(j)) d = he[j];
      if (a == M_EN_BASE + AW'(j)) d = me[j];
    end
    if (a == H_CTRL) d = hc;
    if (a == M_CTRL) d = mc;
    return d;
  endfunction

  assign h_rdata_o = rd_sel(h_addr_i, msg, stat, h_en, m_en, h_ctrl, m_ctrl);
  assign m_rdata_o = rd_sel(m_addr_i, msg, stat, h_en, m_en, h_ctrl, m_ctrl);
endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk
  import mbox_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      h_we_i,
  input logic [AW-1:0]             h_addr_i,
  input logic [DW-1:0]             h_wdata_i,
  input logic                      m_we_i,
  input logic [AW-1:0]             m_addr_i,
  input logic [DW-1:0]             m_wdata_i,
  input logic                      h_irq_o,
  input logic                      m_irq_o,
  input logic [DW-1:0]             h_ctrl_i,
  input logic [DW-1:0]             m_ctrl_i,
  input logic [STAT_N-1:0][DW-1:0] stat_i
);
  logic h_ctl_wr, m_ctl_wr;
  assign h_ctl_wr = h_we_i && h_addr_i == H_CTRL;
  assign m_ctl_wr = m_we_i && m_addr_i == M_CTRL;

  // R4
  h2m_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_ctl_wr && h_wdata_i[SEND_B]) |=> m_ctrl_i[PEND_B]);

  // R4
  m2h_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_ctl_wr && m_wdata_i[SEND_B]) |=> h_ctrl_i[PEND_B]);

  // R5
  h_pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_ctrl_i[PEND_B] && !(h_ctl_wr && h_wdata_i[PEND_B])) |=> h_ctrl_i[PEND_B]);

  // R6
  h_pend_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_ctl_wr && m_wdata_i[SEND_B] && h_ctl_wr && h_wdata_i[PEND_B]) |=> h_ctrl_i[PEND_B]);

  // R7
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_we_i && m_addr_i == STAT_BASE && m_wdata_i[7]) |=> stat_i[0][7]);

  // R9
  h_irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_ctrl_i[PEND_B] && !h_ctrl_i[MASK_B]) |-> h_irq_o);

  // R9
  h_irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!h_ctrl_i[PEND_B] && stat_i == '0) |-> !h_irq_o);

  // R9
  m_irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m_ctrl_i[PEND_B] && stat_i == '0) |-> !m_irq_o);
endmodule

bind mbox_regs mbox_regs_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .h_we_i(h_we_i), .h_addr_i(h_addr_i), .h_wdata_i(h_wdata_i),
  .m_we_i(m_we_i), .m_addr_i(m_addr_i), .m_wdata_i(m_wdata_i),
  .h_irq_o(h_irq_o), .m_irq_o(m_irq_o),
  .h_ctrl_i(h_ctrl), .m_ctrl_i(m_ctrl), .stat_i(stat)
);

// File: tb/test_mbox_regs.sv
`timescale 1ns/1ps
module test_mbox_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       h_we = 1'b0, m_we = 1'b0;
  logic [4:0] h_addr = '0, m_addr = '0;
  logic [7:0] h_wdata = '0, m_wdata = '0;
  logic [7:0] h_rdata, m_rdata;
  logic       h_irq, m_irq;
  int         n_tot = 0, n_bad = 0;

  always #2 clk = ~clk;

  mbox_regs i_mbox_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .h_we_i(h_we), .h_addr_i(h_addr), .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .m_we_i(m_we), .m_addr_i(m_addr), .m_wdata_i(m_wdata), .m_rdata_o(m_rdata),
    .h_irq_o(h_irq), .m_irq_o(m_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic mw(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); m_we = 1'b1; m_addr = a; m_wdata = d;
    @(negedge clk); m_we = 1'b0;
  endtask

  task automatic bw(input logic [4:0] ha, input logic [7:0] hd,
                    input logic [4:0] ma, input logic [7:0] md);
    @(negedge clk);
    h_we = 1'b1; h_addr = ha; h_wdata = hd;
    m_we = 1'b1; m_addr = ma; m_wdata = md;
    @(negedge clk); h_we = 1'b0; m_we = 1'b0;
  endtask

  task automatic ch(input string req, input logic [4:0] a, input logic [7:0] exp);
    h_addr = a; #1; chk(req, h_rdata, exp);
  endtask

  task automatic cm(input string req, input logic [4:0] a, input logic [7:0] exp);
    m_addr = a; #1; chk(req, m_rdata, exp);
  endtask

  task automatic cirq(input string req, input logic eh, input logic em);
    #1;
    chk({req, " h_irq"}, {7'd0, h_irq}, {7'd0, eh});
    chk({req, " m_irq"}, {7'd0, m_irq}, {7'd0, em});
  endtask

  initial begin
    #(200000 * 4);
    n_tot++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state everywhere
    for (int a = 0; a < 32; a++) begin
      ch("R1", 5'(a), 8'h00);
      cm("R1", 5'(a), 8'h00);
    end
    cirq("R1", 1'b0, 1'b0);

    // R2: host writes seen by mgmt, mgmt writes seen by host
    for (int a = 0; a < 16; a++) begin
      hw(5'(a), 8'(a * 37 + 5));
      cm("R2", 5'(a), 8'(a * 37 + 5));
      mw(5'(a), 8'(a * 91 + 3));
      ch("R2", 5'(a), 8'(a * 91 + 3));
    end

    // R3: same-address collision, mgmt wins
    for (int a = 0; a < 16; a++) begin
      bw(5'(a), 8'(~(a * 7)), 5'(a), 8'(a * 13 + 1));
      ch("R3", 5'(a), 8'(a * 13 + 1));
      cm("R3", 5'(a), 8'(a * 13 + 1));
    end
    bw(5'd3, 8'hA5, 5'd9, 8'h5A);
    ch("R3", 5'd3, 8'hA5);
    ch("R3", 5'd9, 8'h5A);

    // R10: unmapped range
    for (int a = 24; a < 32; a++) begin
      hw(5'(a), 8'hFF);
      mw(5'(a), 8'hFF);
      ch("R10", 5'(a), 8'h00);
      cm("R10", 5'(a), 8'h00);
    end
    ch("R10", 5'd8, 8'(8 * 13 + 1));
    for (int a = 16; a < 24; a++) ch("R10", 5'(a), 8'h00);
    cirq("R10", 1'b0, 1'b0);

    // R4: host rings mgmt
    hw(5'h13, 8'h01);
    cm("R4", 5'h12, 8'h80);
    ch("R4", 5'h13, 8'h00);
    cirq("R4", 1'b0, 1'b1);

    // R5: write 0 keeps pending, write 1 clears
    mw(5'h12, 8'h00);
    cm("R5", 5'h12, 8'h80);
    mw(5'h12, 8'h80);
    cm("R5", 5'h12, 8'h00);
    cirq("R5", 1'b0, 1'b0);
    mw(5'h12, 8'h7E);
    cm("R5", 5'h12, 8'h02);
    hw(5'h13, 8'h01);
    cm("R5", 5'h12, 8'h82);
    cirq("R9 masked", 1'b0, 1'b0);
    mw(5'h12, 8'h80);
    cm("R5", 5'h12, 8'h00);

    // R4: mgmt rings host
    mw(5'h12, 8'h01);
    ch("R4", 5'h13, 8'h80);
    cm("R4", 5'h12, 8'h00);
    cirq("R4", 1'b1, 1'b0);

    // R6: ring and clear in the same cycle
    bw(5'h13, 8'h80, 5'h12, 8'h01);
    ch("R6", 5'h13, 8'h80);
    hw(5'h13, 8'h80);
    ch("R6", 5'h13, 8'h00);
    bw(5'h13, 8'h01, 5'h12, 8'h80);
    cm("R6", 5'h12, 8'h80);
    mw(5'h12, 8'h80);
    cm("R6", 5'h12, 8'h00);
    cirq("R6", 1'b0, 1'b0);

    // R8: foreign control and enable writes ignored
    hw(5'h12, 8'h83);
    cm("R8", 5'h12, 8'h00);
    ch("R8", 5'h13, 8'h00);
    mw(5'h13, 8'h83);
    ch("R8", 5'h13, 8'h00);
    cm("R8", 5'h12, 8'h00);
    hw(5'h14, 8'hFF); hw(5'h15, 8'hFF);
    mw(5'h16, 8'hFF); mw(5'h17, 8'hFF);
    for (int a = 20; a < 24; a++) ch("R8", 5'(a), 8'h00);
    cirq("R8", 1'b0, 1'b0);

    // R7: per-bit set by mgmt, clear by host
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < 8; b++) begin
        mw(5'(16 + s), 8'(1 << b));
        ch("R7", 5'(16 + s), 8'(1 << b));
        hw(5'(16 + s), 8'(~(1 << b)));
        cm("R7", 5'(16 + s), 8'(1 << b));
        hw(5'(16 + s), 8'(1 << b));
        cm("R7", 5'(16 + s), 8'h00);
      end
    end
    mw(5'h10, 8'h01);
    mw(5'h10, 8'h02);
    ch("R7", 5'h10, 8'h03);
    mw(5'h10, 8'h0C);
    bw(5'h10, 8'hFF, 5'h10, 8'h03);
    ch("R7 race", 5'h10, 8'h03);
    hw(5'h10, 8'hFF);
    ch("R7", 5'h10, 8'h00);

    // R9: status vs enable sweep
    for (int s = 0; s < 2; s++) begin
      for (int eb = 0; eb < 8; eb++) begin
        hw(5'(22 + s), 8'(1 << eb));
        mw(5'(20 + s), 8'(1 << ((eb + 1) % 8)));
        for (int sb = 0; sb < 8; sb++) begin
          mw(5'(16 + s), 8'(1 << sb));
          cirq("R9", sb == eb, sb == ((eb + 1) % 8));
          hw(5'(16 + s), 8'hFF);
          cirq("R9", 1'b0, 1'b0);
        end
      end
      hw(5'(22 + s), 8'h00);
      mw(5'(20 + s), 8'h00);
    end

    // R9: mask blocks pending but not enabled status
    hw(5'h16, 8'h80);
    hw(5'h13, 8'h02);
    mw(5'h12, 8'h01);
    ch("R9", 5'h13, 8'h82);
    cirq("R9", 1'b0, 1'b0);
    mw(5'h10, 8'h80);
    cirq("R9", 1'b1, 1'b0);
    hw(5'h10, 8'h80);
    cirq("R9", 1'b0, 1'b0);
    hw(5'h13, 8'h80);
    ch("R9", 5'h13, 8'h00);

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule